// File: doc/BRIEF.md
# Image Sensor Register Initialization Sequencer

This block brings an image sensor out of power-up by replaying a fixed list of 16-bit register operations over I2C. After a start pulse it resets the I2C bus controller, waits out a power-up interval, and then works through a small constant table. Most table rows are plain register writes. The sequence also includes a chip-version read, one write that must be preceded by a settling delay, and a status poll that repeats until the sensor reports idle. The last row starts the sensor streaming.

The block does not toggle SCL or SDA itself. It issues whole transactions to a separate bit-level I2C engine through a command interface. Each command carries a start strobe, a direction, a 7-bit device address, a byte count and up to four bytes of write data. The engine answers with a done strobe, a negative-acknowledge flag and two bytes of read data. Delays are counted in ticks of a one-millisecond strobe, so simulation can run with a fast tick. When the sequence finishes, the block reports the chip version it read, the number of write frames the sensor acknowledged, and whether the run succeeded.

Top module: `cam_init_seq`

## Requirements
- R1: While in reset and afterwards with no start pulse, busy, done, error, chip_ver, frames, bus_rst and cmd_start are all 0.
- R2: A start pulse while idle produces a one-cycle bus_rst. No command is issued until PWRUP_MS ticks of ms_tick have been seen after that pulse; the first command follows within one further tick.
- R3: Row 0 reads register 0x3000. The block first issues a 2-byte write (cmd_rw=0) whose bytes are the register high byte and low byte, in cmd_wdata[31:24] and [23:16]. It then issues a 2-byte read (cmd_rw=1). The returned cmd_rdata (high byte in [15:8]) is held on chip_ver. Every command addresses device 7'h3C.
- R4: Each write row is one 4-byte command (cmd_wdata = register high, register low, data high, data low from bit 31 down). The rows are issued in this order: 3386=0501, 3386=0500, 341E=8F09, 341C=0250, 341E=8F09, 341E=8F08, 3202=0008, 338C=A103, 3390=0002, 301A=02CC.
- R5: After the 341C=0250 write completes, at least PLL_WAIT_MS ticks pass before the second 341E=8F09 write is issued, and at most one more tick.
- R6: The second-to-last row reads register 0x3390 (address write, then 2-byte read). The read is repeated until the returned low byte cmd_rdata[7:0] is zero, whatever the high byte holds. Only then is the final row issued.
- R7: If POLL_MAX poll reads all return a non-zero low byte, the sequence stops with error=1 and done=1, and the final row is never written.
- R8: A transaction that completes with cmd_nack=1 aborts the sequence. error and done go to 1, busy drops, and no further command is issued.
- R9: frames counts the write frames the sensor acknowledged. A run ends with done=1 and error=0 only when the acknowledged write bytes equal 4*(rows-2), which is 40 bytes or 10 frames for the 12-row table.
- R10: A start pulse while busy is ignored. It produces no bus reset and does not change the command sequence.
- R11: Each accepted start clears frames, error and done on the cycle busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| bus_rst | output | 1 | One-cycle reset for the I2C controller |
| cmd_start | output | 1 | Command strobe to the I2C engine |
| cmd_rw | output | 1 | 1 = read, 0 = write |
| cmd_dev | output | 7 | 7-bit device address |
| cmd_len | output | 3 | Byte count of the command |
| cmd_wdata | output | 32 | Write bytes, first byte in [31:24] |
| cmd_done | input | 1 | Transaction finished strobe |
| cmd_nack | input | 1 | Negative acknowledge, valid with cmd_done |
| cmd_rdata | input | 16 | Read bytes, first byte in [15:8] |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence ended; held until next start |
| error | output | 1 | Sequence failed |
| chip_ver | output | 16 | Version read from register 0x3000 |
| frames | output | FRAME_W | Acknowledged write frames |

## Verification
The bench builds the block with PWRUP_MS=3, PLL_WAIT_MS=2 and POLL_MAX=4. It also selects the registered-table variant (ROM_REG=1). With these values a full run, both timed waits and a poll timeout each fit into a few hundred cycles of a tick every 16 clocks. The short poll bound lets the timeout path be reached after only four busy reads. The registered table adds a pipeline stage between the index and the decoded row, and this exercises the fetch/decode split.

// File: rtl/cam_init_pkg.sv
package cam_init_pkg;

   typedef enum logic [1:0] {
      K_WR     = 2'd0,
      K_WR_DLY = 2'd1,
      K_VER    = 2'd2,
      K_POLL   = 2'd3
   } row_kind_t;

   typedef struct packed {
      row_kind_t   kind;
      logic [15:0] reg_addr;
      logic [15:0] value;
   } cfg_row_t;

   localparam int unsigned TABLE_LEN = 12;
   localparam int unsigned NON_WRITE_ROWS = 2;

   function automatic cfg_row_t cfg_table(input int unsigned i);
      cfg_row_t r;
      case (i)
         0:       r = '{K_VER,    16'h3000, 16'h0000};
         1:       r = '{K_WR,     16'h3386, 16'h0501};
         2:       r = '{K_WR,     16'h3386, 16'h0500};
         3:       r = '{K_WR,     16'h341E, 16'h8F09};
         4:       r = '{K_WR,     16'h341C, 16'h0250};
         5:       r = '{K_WR_DLY, 16'h341E, 16'h8F09};
         6:       r = '{K_WR,     16'h341E, 16'h8F08};
         7:       r = '{K_WR,     16'h3202, 16'h0008};
         8:       r = '{K_WR,     16'h338C, 16'hA103};
         9:       r = '{K_WR,     16'h3390, 16'h0002};
         10:      r = '{K_POLL,   16'h3390, 16'h0000};
         11:      r = '{K_WR,     16'h301A, 16'h02CC};
         default: r = '{K_WR,     16'h301A, 16'h02CC};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cam_cfg_rom.sv
module cam_cfg_rom
   import cam_init_pkg::*;
#(
   parameter int unsigned IDX_W   = 4,
   parameter bit          ROM_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output cfg_row_t         row
);

   generate
      if (2**IDX_W < TABLE_LEN) begin : g_bad_idx
         $error("cam_cfg_rom: IDX_W too narrow for table");
      end
      if (ROM_REG) begin : g_reg
         cfg_row_t row_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q <= cfg_table(0);
            else        row_q <= cfg_table(int'(idx));
         end
         assign row = row_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign row = cfg_table(int'(idx));
      end
   endgenerate

endmodule

// File: rtl/cam_ms_timer.sv
module cam_ms_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R2/R5: time passes only on ticks
   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !tick |=> $stable(cnt));
   // R5: once expired, stays expired until reloaded
   a_r5_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      expired && !load |=> expired);

endmodule

// File: rtl/cam_init_seq.sv
module cam_init_seq
   import cam_init_pkg::*;
#(
   parameter int unsigned PWRUP_MS    = 200,
   parameter int unsigned PLL_WAIT_MS = 50,
   parameter int unsigned POLL_MAX    = 1024,
   parameter logic [6:0]  DEV_ADDR    = 7'h3C,
   parameter int unsigned FRAME_W     = 8,
   parameter bit          ROM_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               ms_tick,
   output logic               bus_rst,
   output logic               cmd_start,
   output logic               cmd_rw,
   output logic [6:0]         cmd_dev,
   output logic [2:0]         cmd_len,
   output logic [31:0]        cmd_wdata,
   input  logic               cmd_done,
   input  logic               cmd_nack,
   input  logic [15:0]        cmd_rdata,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic [15:0]        chip_ver,
   output logic [FRAME_W-1:0] frames
);

   localparam int unsigned IDX_W   = $clog2(TABLE_LEN);
   localparam int unsigned MAX_MS  = (PWRUP_MS > PLL_WAIT_MS) ? PWRUP_MS : PLL_WAIT_MS;
   localparam int unsigned TMR_W   = $clog2(MAX_MS + 1);
   localparam int unsigned POLL_W  = $clog2(POLL_MAX + 1);
   localparam int unsigned BYTE_W  = FRAME_W + 2;
   localparam logic [BYTE_W-1:0] BYTES_EXP = BYTE_W'(4 * (TABLE_LEN - NON_WRITE_ROWS));
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(TABLE_LEN - 1);
   localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

   generate
      if (PWRUP_MS < 1 || PLL_WAIT_MS < 1) begin : g_bad_delay
         $error("cam_init_seq: delays must be at least one tick");
      end
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("cam_init_seq: POLL_MAX must be at least 1");
      end
      if (2**FRAME_W <= TABLE_LEN) begin : g_bad_frame
         $error("cam_init_seq: FRAME_W too narrow");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_BUSRST, S_PWRWAIT, S_FETCH, S_DECODE, S_DLYWAIT,
      S_WR, S_WRW, S_RA, S_RAW, S_RD, S_RDW, S_NEXT, S_END
   } seq_state_t;

   seq_state_t           state;
   logic [IDX_W-1:0]     idx;
   cfg_row_t             row;
   logic [POLL_W-1:0]    poll_cnt;
   logic [BYTE_W-1:0]    byte_cnt;
   logic                 waited;
   logic                 done_q, error_q;
   logic [15:0]          ver_q;
   logic                 tmr_load, tmr_expired;
   logic [TMR_W-1:0]     tmr_val;

   cam_cfg_rom #(.IDX_W(IDX_W), .ROM_REG(ROM_REG)) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (idx),
      .row   (row)
   );

   cam_ms_timer #(.CNT_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (ms_tick),
      .expired  (tmr_expired)
   );

   // timer control
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = TMR_W'(PWRUP_MS);
      if (state == S_BUSRST) begin
         tmr_load = 1'b1;
      end else if (state == S_DECODE && row.kind == K_WR_DLY && !waited) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(PLL_WAIT_MS);
      end
   end

   // command interface
   always_comb begin
      cmd_start = 1'b0;
      cmd_rw    = 1'b0;
      cmd_len   = 3'd0;
      cmd_wdata = 32'h0;
      cmd_dev   = DEV_ADDR;
      case (state)
         S_WR: begin
            cmd_start = 1'b1;
            cmd_len   = 3'd4;
            cmd_wdata = {row.reg_addr, row.value};
         end
         S_RA: begin
            cmd_start = 1'b1;
            cmd_len   = 3'd2;
            cmd_wdata = {row.reg_addr, 16'h0000};
         end
         S_RD: begin
            cmd_start = 1'b1;
            cmd_rw    = 1'b1;
            cmd_len   = 3'd2;
         end
         default: ;
      endcase
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         poll_cnt <= '0;
         byte_cnt <= '0;
         waited   <= 1'b0;
         done_q   <= 1'b0;
         error_q  <= 1'b0;
         ver_q    <= 16'h0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               byte_cnt <= '0;
               error_q  <= 1'b0;
               done_q   <= 1'b0;
               poll_cnt <= '0;
               waited   <= 1'b0;
               idx      <= '0;
               state    <= S_BUSRST;
            end
            S_BUSRST:  state <= S_PWRWAIT;
            S_PWRWAIT: if (tmr_expired) state <= S_FETCH;
            S_FETCH:   state <= S_DECODE;
            S_DECODE: begin
               case (row.kind)
                  K_WR:     state <= S_WR;
                  K_WR_DLY: begin
                     if (!waited) begin
                        waited <= 1'b1;
                        state  <= S_DLYWAIT;
                     end else begin
                        state  <= S_WR;
                     end
                  end
                  default:  state <= S_RA;
               endcase
            end
            S_DLYWAIT: if (tmr_expired) state <= S_WR;
            S_WR:      state <= S_WRW;
            S_WRW: if (cmd_done) begin
               if (cmd_nack) begin
                  error_q <= 1'b1;
                  state   <= S_END;
               end else begin
                  byte_cnt <= byte_cnt + BYTE_W'(4);
                  state    <= S_NEXT;
               end
            end
            S_RA:      state <= S_RAW;
            S_RAW: if (cmd_done) begin
               if (cmd_nack) begin
                  error_q <= 1'b1;
                  state   <= S_END;
               end else begin
                  state   <= S_RD;
               end
            end
            S_RD:      state <= S_RDW;
            S_RDW: if (cmd_done) begin
               if (cmd_nack) begin
                  error_q <= 1'b1;
                  state   <= S_END;
               end else if (row.kind == K_VER) begin
                  ver_q <= cmd_rdata;
                  state <= S_NEXT;
               end else if (cmd_rdata[7:0] == 8'h00) begin
                  state <= S_NEXT;
               end else if (poll_cnt == POLL_LAST) begin
                  error_q <= 1'b1;
                  state   <= S_END;
               end else begin
                  poll_cnt <= poll_cnt + 1'b1;
                  state    <= S_RA;
               end
            end
            S_NEXT: begin
               poll_cnt <= '0;
               waited   <= 1'b0;
               if (idx == LAST_IDX) begin
                  if (byte_cnt != BYTES_EXP) error_q <= 1'b1;
                  state <= S_END;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= S_FETCH;
               end
            end
            S_END: begin
               done_q <= 1'b1;
               state  <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign bus_rst  = (state == S_BUSRST);
   assign busy     = (state != S_IDLE);
   assign done     = done_q;
   assign error    = error_q;
   assign chip_ver = ver_q;
   assign frames   = byte_cnt[BYTE_W-1:2];

   // R8: a refused transaction ends the run with an error
   a_r8_nack_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_done && cmd_nack |=> ##1 (!busy && error && done));
   // R10: start while busy never triggers another bus reset
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bus_rst && start |=> !bus_rst);
   // R11: new run begins with cleared results
   a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (frames == '0 && !error && !done));
   // R1: commands only while running
   a_r1_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> busy);
   // R7: poll retries stay inside the bound
   a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt <= POLL_LAST);
   // R9: done and busy never overlap
   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

endmodule

// File: tb/tb_cam_init_seq.sv
module tb_cam_init_seq;

   localparam int CLK_PERIOD = 10;
   localparam int PWR  = 3;
   localparam int PLLW = 2;
   localparam int PMAX = 4;
   localparam logic [15:0] VER = 16'h2B3D;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ms_tick = 1'b0;
   logic        bus_rst, cmd_start, cmd_rw;
   logic [6:0]  cmd_dev;
   logic [2:0]  cmd_len;
   logic [31:0] cmd_wdata;
   logic        cmd_done = 1'b0, cmd_nack = 1'b0;
   logic [15:0] cmd_rdata = 16'h0;
   logic        busy, done, error;
   logic [15:0] chip_ver;
   logic [7:0]  frames;

   cam_init_seq #(.PWRUP_MS(PWR), .PLL_WAIT_MS(PLLW), .POLL_MAX(PMAX),
                  .DEV_ADDR(7'h3C), .FRAME_W(8), .ROM_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
      .bus_rst(bus_rst), .cmd_start(cmd_start), .cmd_rw(cmd_rw),
      .cmd_dev(cmd_dev), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
      .cmd_done(cmd_done), .cmd_nack(cmd_nack), .cmd_rdata(cmd_rdata),
      .busy(busy), .done(done), .error(error), .chip_ver(chip_ver),
      .frames(frames));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_w(input int i);
      case (i)
         0: return 32'h33860501;  1: return 32'h33860500;
         2: return 32'h341E8F09;  3: return 32'h341C0250;
         4: return 32'h341E8F09;  5: return 32'h341E8F08;
         6: return 32'h32020008;  7: return 32'h338CA103;
         8: return 32'h33900002;  default: return 32'h301A02CC;
      endcase
   endfunction

   // engine model and logging
   logic [31:0] wlog [0:31];
   int   wcount, n_starts, n_ver_rd, n_poll_rd, n_busrst, nack_at, poll_busy;
   int   bad_dev, bad_ra, tk_pwr, tk_pll, pwr_ticks, pll_ticks;
   bit   pwr_arm, pll_arm;
   logic [15:0] last_addr;
   logic [31:0] last_w;

   task automatic clear_log();
      wcount = 0; n_starts = 0; n_ver_rd = 0; n_poll_rd = 0; n_busrst = 0;
      bad_dev = 0; bad_ra = 0; pwr_ticks = -1; pll_ticks = -1;
      pwr_arm = 0; pll_arm = 0; last_w = 32'h0; last_addr = 16'h0;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (cmd_start) begin
            logic [15:0] rd;
            bit nk;
            n_starts++;
            nk = (nack_at == n_starts);
            rd = 16'h0;
            if (cmd_dev != 7'h3C) bad_dev++;
            if (!cmd_rw) begin
               if (cmd_len == 3'd4) begin
                  if (wcount < 32) wlog[wcount] = cmd_wdata;
                  wcount++;
                  last_w = cmd_wdata;
               end else begin
                  if (cmd_len != 3'd2 || cmd_wdata[15:0] != 16'h0) bad_ra++;
                  last_addr = cmd_wdata[31:16];
                  last_w = 32'h0;
               end
            end else begin
               if (last_addr == 16'h3000) begin
                  n_ver_rd++; rd = VER;
               end else if (last_addr == 16'h3390) begin
                  n_poll_rd++;
                  rd = (n_poll_rd <= poll_busy) ? 16'h0005 : 16'h7700;
               end
            end
            repeat (2) @(posedge clk);
            #1 cmd_done = 1'b1; cmd_nack = nk; cmd_rdata = rd;
            @(posedge clk);
            #1 cmd_done = 1'b0; cmd_nack = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (bus_rst) begin
            n_busrst++; tk_pwr = 0; pwr_arm = 1;
         end else if (ms_tick) begin
            tk_pwr++; tk_pll++;
         end
         if (cmd_start && pwr_arm) begin pwr_ticks = tk_pwr; pwr_arm = 0; end
         if (cmd_done && last_w == 32'h341C0250) begin tk_pll = 0; pll_arm = 1; end
         if (cmd_start && pll_arm && cmd_len == 3'd4 && cmd_wdata == 32'h341E8F09) begin
            pll_ticks = tk_pll; pll_arm = 0;
         end
      end
   end

   initial begin
      forever begin
         repeat (15) @(posedge clk);
         #1 ms_tick = 1'b1;
         @(posedge clk);
         #1 ms_tick = 1'b0;
      end
   end

   task automatic pulse_start();
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done && !busy) begin ok = 1; break; end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!busy && !done && !error && frames == 0 && chip_ver == 0 && !bus_rst && !cmd_start,
            "R1", "idle outputs", {busy, done, error, bus_rst, cmd_start}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(!busy && !done && !cmd_start && n_starts == 0, "R1", "no activity without start",
            n_starts, 0);
   endtask

   task automatic t_normal();
      bit ok;
      clear_log(); nack_at = 0; poll_busy = 2;
      pulse_start();
      repeat (40) @(posedge clk);
      #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;   // R10: start while busy
      wait_done(ok);
      check(ok, "R9", "run finished", ok, 1);
      check(n_busrst == 1, "R10", "bus resets per run", n_busrst, 1);
      check(pwr_ticks >= PWR && pwr_ticks <= PWR + 1, "R2", "power-up ticks", pwr_ticks, PWR);
      check(chip_ver == VER && n_ver_rd == 1, "R3", "chip version", chip_ver, VER);
      check(bad_dev == 0 && bad_ra == 0, "R3", "device addr and address writes", bad_dev + bad_ra, 0);
      check(wcount == 10, "R4", "write frame count", wcount, 10);
      for (int i = 0; i < 10; i++)
         if (i < wcount) check(wlog[i] == exp_w(i), "R4", $sformatf("frame %0d", i), wlog[i], exp_w(i));
      check(pll_ticks >= PLLW && pll_ticks <= PLLW + 1, "R5", "PLL wait ticks", pll_ticks, PLLW);
      check(n_poll_rd == 3, "R6", "poll reads until low byte zero", n_poll_rd, 3);
      check(frames == 10 && !error && done, "R9", "frames/error", {frames, error}, {8'd10, 1'b0});
   endtask

   task automatic t_nack();
      bit ok;
      clear_log(); nack_at = 4; poll_busy = 0;
      pulse_start();
      wait_done(ok);
      repeat (30) @(negedge clk);
      check(ok && error && done && !busy, "R8", "abort flags", {error, done, busy}, 3'b110);
      check(frames == 1, "R8", "frames before nack", frames, 1);
      check(n_starts == 4, "R8", "no command after nack", n_starts, 4);
   endtask

   task automatic t_restart();
      bit ok;
      clear_log(); nack_at = 0; poll_busy = 0;
      pulse_start();
      @(negedge clk);
      check(busy && frames == 0 && !error && !done, "R11", "cleared on start",
            {busy, frames, error, done}, {1'b1, 8'd0, 2'b00});
      wait_done(ok);
      check(ok && !error && frames == 10 && n_poll_rd == 1, "R11", "clean rerun", frames, 10);
   endtask

   task automatic t_poll_timeout();
      bit ok;
      clear_log(); nack_at = 0; poll_busy = 1000;
      pulse_start();
      wait_done(ok);
      check(ok && error && done, "R7", "timeout flags", {error, done}, 2'b11);
      check(n_poll_rd == PMAX, "R7", "poll read count", n_poll_rd, PMAX);
      check(wcount == 9 && frames == 9, "R7", "final row not written", wcount, 9);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_normal();
            t_nack();
            t_restart();
            t_poll_timeout();
         end
         begin
            repeat (150000) @(posedge clk);
            check(0, "WDOG", "watchdog expired", 1, 0);
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule